// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the address-latch strobe and the active-low program-store strobe for an 8051-style external memory bus. It runs on the oscillator clock and is told, through a phase index, where the current machine cycle stands. A machine cycle is twelve oscillator periods split into two halves of six. Each half carries one address-latch window followed by one program-store window. The block also decides whether the current code fetch goes to on-chip or off-chip code memory. It reports that decision as a fetch-select output, so the surrounding fetch logic can steer the read.

Several conditions change the pattern. A cycle that moves external data keeps the first latch pulse, drops the second one and suppresses both program-store strobes. A quiet-latch setting holds the latch line high unless a data-move or code-read instruction is running. That setting has no effect while code comes from off-chip. Idle mode parks both strobes high and power-down parks both low. All outputs are registered. Each output therefore reflects the inputs sampled at the previous rising clock edge.

Top module: `bus_strobe_gen`

## Requirements
- R1: In normal operation `ale` is 1 for phases 0, 1, 6 and 7 of the twelve-phase machine cycle and 0 for the other phases. This gives two pulses of two oscillator periods each per machine cycle.
- R2: While `xdata_cyc` is 1, the pulse at phases 6 and 7 is dropped (`ale` stays 0 there). The pulse at phases 0 and 1 is kept.
- R3: When the fetch is external and `xdata_cyc` is 0, `psen_n` is 0 for phases 2, 3, 4, 8, 9 and 10 and 1 for the other phases. These are two three-period assertions, each following the fall of `ale`.
- R4: While `xdata_cyc` is 1, `psen_n` stays 1 for all twelve phases.
- R5: `fetch_ext` is 1 when `int_code_en` is 0. When `int_code_en` is 1, `fetch_ext` is 1 only for `fetch_addr` of 0x1000 or above; 0x0FFF and below give 0.
- R6: When the fetch is internal, `psen_n` stays 1 for every phase.
- R7: With `ale_quiet` = 1, an internal fetch and both `xdata_cyc` and `code_rd_cyc` at 0, `ale` is held at 1 for every phase.
- R8: With `ale_quiet` = 1 and an internal fetch, setting `code_rd_cyc` or `xdata_cyc` restores the R1/R2 pulse pattern.
- R9: With `ale_quiet` = 1 and an external fetch, `ale` and `psen_n` follow R1 and R3 unchanged.
- R10: While `idle_mode` = 1 and `pdown_mode` = 0, `ale` and `psen_n` are both 1.
- R11: While `pdown_mode` = 1, `ale` and `psen_n` are both 0, whatever `idle_mode` is.
- R12: A clock edge with `rst` = 1 sets `ale` to 0, `psen_n` to 1 and `fetch_ext` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| phase | input | 4 | Oscillator period index within the machine cycle, 0 to 11 |
| xdata_cyc | input | 1 | Current machine cycle is an external data move |
| code_rd_cyc | input | 1 | Current instruction is a code-memory table read |
| int_code_en | input | 1 | External-access strap; 1 allows on-chip code fetches |
| fetch_addr | input | 16 | Current code fetch address |
| idle_mode | input | 1 | Idle status |
| pdown_mode | input | 1 | Power-down status |
| ale_quiet | input | 1 | Suppress the latch strobe outside data-move and code-read instructions |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store enable, active low |
| fetch_ext | output | 1 | 1 when the current fetch targets external code memory |

## Verification
The bench sweeps all twelve phases under each mode. A design with the skip on the wrong half, or with the program-store window placed over the latch window, therefore fails phase by phase. It probes the fetch boundary at 0x0FFF and 0x1000, where an off-by-one compare sends one address to the wrong memory. It checks that the quiet-latch setting is ignored on external fetches, because a design that honoured it there would stop latching addresses. It also checks that power-down wins over idle, because the wrong precedence leaves the strobes high while the clock is stopped.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_PDOWN = 2'd2
    } bus_mode_t;

    // Where the current phase sits inside its half machine cycle
    typedef struct packed {
        logic valid;
        logic second_half;
        logic ale_win;
        logic psen_win;
    } slot_t;

    typedef struct packed {
        logic ale;
        logic psen_n;
        logic fetch_ext;
    } strobe_t;

    localparam strobe_t STROBE_RESET = '{ale: 1'b0, psen_n: 1'b1, fetch_ext: 1'b0};

    // Power-down takes precedence over idle
    function automatic bus_mode_t pick_mode(input logic idle, input logic pdown);
        if (pdown)
            return MODE_PDOWN;
        else if (idle)
            return MODE_IDLE;
        return MODE_RUN;
    endfunction

    // Latch strobe may pulse unless quiet mode applies to an internal fetch
    function automatic logic ale_allowed(input logic quiet, input logic ext,
                                         input logic xdata, input logic code_rd);
        return !quiet || ext || xdata || code_rd;
    endfunction

endpackage

// File: rtl/phase_slot.sv
module phase_slot
    import bus_strobe_pkg::*;
#(
    parameter int CYC_LEN = 12,
    parameter int ALE_W   = 2,
    parameter int PSEN_W  = 3,
    parameter int PH_W    = $clog2(CYC_LEN)
) (
    input  logic [PH_W-1:0] phase,
    output slot_t           slot
);
    localparam int HALF = CYC_LEN / 2;
    localparam logic [PH_W-1:0] HALF_P    = PH_W'(HALF);
    localparam logic [PH_W-1:0] LEN_P     = PH_W'(CYC_LEN);
    localparam logic [PH_W-1:0] ALE_END   = PH_W'(ALE_W);
    localparam logic [PH_W-1:0] PSEN_END  = PH_W'(ALE_W + PSEN_W);

    logic [PH_W-1:0] offset;
    logic            upper;

    always_comb begin
        upper  = (phase >= HALF_P);
        offset = upper ? (phase - HALF_P) : phase;
        slot.valid       = (phase < LEN_P);
        slot.second_half = upper;
        slot.ale_win     = slot.valid && (offset < ALE_END);
        slot.psen_win    = slot.valid && (offset >= ALE_END) && (offset < PSEN_END);
    end

endmodule

// File: rtl/fetch_select.sv
module fetch_select #(
    parameter int ADDR_W        = 16,
    parameter int INT_CODE_SIZE = 4096
) (
    input  logic              int_code_en,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ext
);
    generate
        if (INT_CODE_SIZE >= (2 ** ADDR_W)) begin : g_all_internal
            assign fetch_ext = !int_code_en;
        end else if (INT_CODE_SIZE <= 0) begin : g_all_external
            assign fetch_ext = 1'b1;
        end else begin : g_compare
            localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(INT_CODE_SIZE);
            assign fetch_ext = !int_code_en || (fetch_addr >= LIMIT);
        end
    endgenerate

endmodule

// File: rtl/strobe_gate.sv
module strobe_gate
    import bus_strobe_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  slot_t   slot,
    input  logic    ext_fetch,
    input  logic    xdata_cyc,
    input  logic    code_rd_cyc,
    input  logic    idle_mode,
    input  logic    pdown_mode,
    input  logic    ale_quiet,
    output strobe_t out_q
);
    bus_mode_t mode;
    strobe_t   out_d;
    logic      pulse_ok;
    logic      ale_pulse;
    logic      psen_act;

    always_comb begin
        mode      = pick_mode(idle_mode, pdown_mode);
        pulse_ok  = ale_allowed(ale_quiet, ext_fetch, xdata_cyc, code_rd_cyc);
        ale_pulse = slot.ale_win && !(slot.second_half && xdata_cyc);
        psen_act  = ext_fetch && !xdata_cyc && slot.psen_win;
        out_d.fetch_ext = ext_fetch;
        unique case (mode)
            MODE_PDOWN: begin
                out_d.ale    = 1'b0;
                out_d.psen_n = 1'b0;
            end
            MODE_IDLE: begin
                out_d.ale    = 1'b1;
                out_d.psen_n = 1'b1;
            end
            default: begin
                out_d.ale    = pulse_ok ? ale_pulse : 1'b1;
                out_d.psen_n = !psen_act;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= STROBE_RESET;
        else
            out_q <= out_d;
    end

    // R11: power-down parks both strobes low
    a_r11_pdown_low: assert property (@(posedge clk) disable iff (rst)
        pdown_mode |=> (!out_q.ale && !out_q.psen_n));

    // R10: idle parks both strobes high
    a_r10_idle_high: assert property (@(posedge clk) disable iff (rst)
        (idle_mode && !pdown_mode) |=> (out_q.ale && out_q.psen_n));

    // R6: on-chip fetches never drive the program-store strobe
    a_r6_int_no_psen: assert property (@(posedge clk) disable iff (rst)
        (!ext_fetch && !pdown_mode) |=> out_q.psen_n);

    // R4: data-move cycles carry no program-store strobe
    a_r4_xdata_no_psen: assert property (@(posedge clk) disable iff (rst)
        (xdata_cyc && !pdown_mode) |=> out_q.psen_n);

    // R3: program-store strobe only starts once the latch strobe is low
    a_r3_psen_after_ale: assert property (@(posedge clk) disable iff (rst)
        $fell(out_q.psen_n) |-> !out_q.ale);

    // R2: second-half latch pulse dropped on data-move cycles
    a_r2_xdata_skip: assert property (@(posedge clk) disable iff (rst)
        (xdata_cyc && slot.second_half && slot.valid && !idle_mode && !pdown_mode)
            |=> !out_q.ale);

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bus_strobe_pkg::*;
#(
    parameter int CYC_LEN       = 12,
    parameter int ALE_W         = 2,
    parameter int PSEN_W        = 3,
    parameter int ADDR_W        = 16,
    parameter int INT_CODE_SIZE = 4096,
    localparam int PH_W         = $clog2(CYC_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   phase,
    input  logic              xdata_cyc,
    input  logic              code_rd_cyc,
    input  logic              int_code_en,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              idle_mode,
    input  logic              pdown_mode,
    input  logic              ale_quiet,
    output logic              ale,
    output logic              psen_n,
    output logic              fetch_ext
);
    slot_t   slot;
    logic    ext_now;
    strobe_t strobes;

    phase_slot #(
        .CYC_LEN(CYC_LEN),
        .ALE_W  (ALE_W),
        .PSEN_W (PSEN_W),
        .PH_W   (PH_W)
    ) u_slot (
        .phase(phase),
        .slot (slot)
    );

    fetch_select #(
        .ADDR_W       (ADDR_W),
        .INT_CODE_SIZE(INT_CODE_SIZE)
    ) u_fetch (
        .int_code_en(int_code_en),
        .fetch_addr (fetch_addr),
        .fetch_ext  (ext_now)
    );

    strobe_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .slot       (slot),
        .ext_fetch  (ext_now),
        .xdata_cyc  (xdata_cyc),
        .code_rd_cyc(code_rd_cyc),
        .idle_mode  (idle_mode),
        .pdown_mode (pdown_mode),
        .ale_quiet  (ale_quiet),
        .out_q      (strobes)
    );

    assign ale       = strobes.ale;
    assign psen_n    = strobes.psen_n;
    assign fetch_ext = strobes.fetch_ext;

    // R5: strap low forces every fetch off-chip
    a_r5_strap_low_ext: assert property (@(posedge clk) disable iff (rst)
        !int_code_en |=> fetch_ext);

endmodule

// File: tb/bus_strobe_gen_test.sv
module bus_strobe_gen_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  phase;
    logic        xdata_cyc, code_rd_cyc, int_code_en;
    logic [15:0] fetch_addr;
    logic        idle_mode, pdown_mode, ale_quiet;
    logic        ale, psen_n, fetch_ext;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Expected per-phase patterns, bit i = phase i
    localparam logic [11:0] ALE_NORM  = 12'h0C3; // phases 0,1,6,7
    localparam logic [11:0] ALE_XDATA = 12'h003; // phases 0,1
    localparam logic [11:0] PSEN_EXT  = 12'h8E3; // low at 2,3,4,8,9,10
    localparam logic [11:0] ALL_HIGH  = 12'hFFF;
    localparam logic [11:0] ALL_LOW   = 12'h000;

    always #4 clk = ~clk;

    bus_strobe_gen uut (
        .clk(clk), .rst(rst), .phase(phase), .xdata_cyc(xdata_cyc),
        .code_rd_cyc(code_rd_cyc), .int_code_en(int_code_en),
        .fetch_addr(fetch_addr), .idle_mode(idle_mode), .pdown_mode(pdown_mode),
        .ale_quiet(ale_quiet), .ale(ale), .psen_n(psen_n), .fetch_ext(fetch_ext)
    );

    task automatic check_bit(input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", what, got, exp);
        end
    endtask

    task automatic set_base(input logic strap, input logic [15:0] addr);
        xdata_cyc = 0; code_rd_cyc = 0; idle_mode = 0; pdown_mode = 0;
        ale_quiet = 0; int_code_en = strap; fetch_addr = addr;
    endtask

    task automatic sweep(input logic [11:0] exp_ale, input logic [11:0] exp_psen,
                         input string tag);
        for (int p = 0; p < 12; p++) begin
            phase = 4'(p);
            @(negedge clk);
            check_bit(ale, exp_ale[p], $sformatf("%s ale phase %0d", tag, p));
            check_bit(psen_n, exp_psen[p], $sformatf("%s psen_n phase %0d", tag, p));
        end
    endtask

    task automatic t_reset;
        rst = 1; set_base(1'b0, 16'h0000); phase = 4'd2;
        repeat (3) @(negedge clk);
        check_bit(ale, 1'b0, "R12 reset ale");
        check_bit(psen_n, 1'b1, "R12 reset psen_n");
        check_bit(fetch_ext, 1'b0, "R12 reset fetch_ext");
        rst = 0;
    endtask

    task automatic t_ext_run;
        set_base(1'b0, 16'h0100);
        sweep(ALE_NORM, PSEN_EXT, "R1 R3 external run");
        check_bit(fetch_ext, 1'b1, "R5 strap low fetch_ext");
    endtask

    task automatic t_int_run;
        set_base(1'b1, 16'h0800);
        sweep(ALE_NORM, ALL_HIGH, "R6 internal run");
        check_bit(fetch_ext, 1'b0, "R5 internal fetch_ext");
    endtask

    task automatic t_xdata;
        set_base(1'b0, 16'h2000); xdata_cyc = 1;
        sweep(ALE_XDATA, ALL_HIGH, "R2 R4 data move");
    endtask

    task automatic t_bounds;
        set_base(1'b1, 16'h0FFF); @(negedge clk);
        check_bit(fetch_ext, 1'b0, "R5 addr 0FFF");
        fetch_addr = 16'h1000; @(negedge clk);
        check_bit(fetch_ext, 1'b1, "R5 addr 1000");
        fetch_addr = 16'hFFFF; @(negedge clk);
        check_bit(fetch_ext, 1'b1, "R5 addr FFFF");
        int_code_en = 0; fetch_addr = 16'h0000; @(negedge clk);
        check_bit(fetch_ext, 1'b1, "R5 strap low addr 0000");
        int_code_en = 1; fetch_addr = 16'h1000;
        sweep(ALE_NORM, PSEN_EXT, "R5 R3 fetch above boundary");
    endtask

    task automatic t_quiet_int;
        set_base(1'b1, 16'h0010); ale_quiet = 1;
        sweep(ALL_HIGH, ALL_HIGH, "R7 quiet internal");
    endtask

    task automatic t_quiet_override;
        set_base(1'b1, 16'h0010); ale_quiet = 1; code_rd_cyc = 1;
        sweep(ALE_NORM, ALL_HIGH, "R8 quiet with code read");
        code_rd_cyc = 0; xdata_cyc = 1;
        sweep(ALE_XDATA, ALL_HIGH, "R8 quiet with data move");
    endtask

    task automatic t_quiet_ext;
        set_base(1'b0, 16'h0010); ale_quiet = 1;
        sweep(ALE_NORM, PSEN_EXT, "R9 quiet external");
    endtask

    task automatic t_idle;
        set_base(1'b0, 16'h3000); idle_mode = 1;
        sweep(ALL_HIGH, ALL_HIGH, "R10 idle");
    endtask

    task automatic t_pdown;
        set_base(1'b0, 16'h3000); idle_mode = 1; pdown_mode = 1;
        sweep(ALL_LOW, ALL_LOW, "R11 power-down over idle");
        idle_mode = 0;
        sweep(ALL_LOW, ALL_LOW, "R11 power-down");
    endtask

    initial begin
        t_reset();
        t_ext_run();
        t_int_run();
        t_xdata();
        t_bounds();
        t_quiet_int();
        t_quiet_override();
        t_quiet_ext();
        t_idle();
        t_pdown();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule